// File: doc/BRIEF.md
# Transmit Holding Empty Interrupt Generator

This block makes the "transmitter ready for more data" interrupt request of a FIFO-mode serial port. It watches the occupancy of the transmit FIFO and the two enable bits, and it keeps an internal empty status. It raises a pending request when that status becomes true. A write of a new character or a read of the interrupt identification register withdraws the request. Software can load as many characters as the FIFO holds, up to 16 by default, while it services the request.

The block does not always flag the empty FIFO at once. It sometimes holds the indication back so that the request does not fire while the last character is still leaving the shifter. The empty status is delayed when the FIFO has never held two or more characters at the same time since the previous empty event. The delay is one frame time minus the final stop bit, counted in oversampling ticks. The serializer supplies the oversampling tick and the frame settings. The FIFO itself lies outside the block.

Top module: `thr_empty_irq`

## Requirements
- R1: After reset the irq output is 0 and the internal empty status is 1, so setting both enables with an empty FIFO raises irq on the following cycle.
- R2: irq is 1 only while both fifo_en and txint_en are 1; dropping either one forces irq to 0 on the same cycle.
- R3: A cycle with thr_wr=1 clears the pending request, so irq is 0 after that clock edge.
- R4: A cycle with iir_rd=1 clears the pending request, so irq is 0 after that clock edge.
- R5: When the FIFO goes from non-empty to empty and it has held at most one character at a time since the last empty event, the empty status and irq appear only after D baud_tick pulses. D = TICKS_PER_BIT*(F-1). F = 1 start bit + (5 + data_len) data bits + parity_en + (1 + two_stop) stop bits, where data_len codes 0..3 stand for 5..8 data bits.
- R6: When the occupancy reached 2 or more since the last empty event, irq rises on the clock edge that follows the FIFO becoming empty, with no delay.
- R7: The two-or-more record is cleared at every new empty event. A later episode that holds only one character is delayed again as in R5.
- R8: A non-zero occupancy during a pending delay cancels it. The next empty state starts a fresh full delay of D ticks.
- R9: A 0-to-1 change of fifo_en or of txint_en while the empty status is 1 and the other enable is 1 raises irq on the next cycle.
- R10: The delay advances only on cycles with baud_tick=1. Cycles without a tick leave the remaining count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | FIFO mode enable bit |
| txint_en | input | 1 | Transmit interrupt enable bit |
| fifo_level | input | LVL_W | Current transmit FIFO occupancy |
| thr_wr | input | 1 | Strobe: write to the holding register |
| iir_rd | input | 1 | Strobe: read of the interrupt identification register |
| baud_tick | input | 1 | Oversampling tick enable (TICKS_PER_BIT per bit) |
| data_len | input | 2 | Data bits code, 0..3 for 5..8 bits |
| parity_en | input | 1 | Parity bit present |
| two_stop | input | 1 | Two stop bits when 1 |
| irq | output | 1 | Transmit-empty interrupt request |

## Verification
A table of every frame shape, from the shortest to the longest, drains a single-character FIFO and counts ticks. This shows that irq stays low one tick before D and rises exactly at D, which separates the correct frame formula from off-by-one-bit or stop-bit mistakes. Episodes that reach two characters show that the delay is skipped, and a later single-character episode shows that the record is cleared. Further directed cases cover a refill that interrupts the delay, cycles with no tick, the enable edges, the masking and both clearing strobes.

// File: rtl/thr_empty_pkg.sv
package thr_empty_pkg;

   // Number of bits in one frame: start + data + parity + stops
   function automatic int unsigned frame_bits(input logic [1:0] data_len,
                                              input logic       parity_en,
                                              input logic       two_stop);
      frame_bits = 1 + 5 + int'(data_len) + int'(parity_en) + 1 + int'(two_stop);
   endfunction

   localparam int unsigned MAX_FRAME_BITS = 12;

endpackage

// File: rtl/thr_occupancy_tracker.sv
module thr_occupancy_tracker #(
   parameter int unsigned LVL_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] fifo_level,
   input  logic             empty_event,
   output logic             multi_seen
);

   initial begin
      if (LVL_W < 2) $error("thr_occupancy_tracker: LVL_W must be at least 2");
   end

   logic level_ge2;
   assign level_ge2 = (fifo_level >= LVL_W'(2));

   always_ff @(posedge clk) begin
      if (!rst_n)            multi_seen <= 1'b0;
      else if (empty_event)  multi_seen <= 1'b0;
      else if (level_ge2)    multi_seen <= 1'b1;
   end

   AST_MULTI_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (level_ge2 && !empty_event) |=> multi_seen);  // R6
   AST_MULTI_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      empty_event |=> !multi_seen);  // R7

endmodule

// File: rtl/thr_delay_timer.sv
module thr_delay_timer #(
   parameter int unsigned LVL_W         = 5,
   parameter int unsigned TICKS_PER_BIT = 16,
   parameter bit          DELAY_EN      = 1'b1,
   parameter int unsigned CNT_W         = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] fifo_level,
   input  logic             multi_seen,
   input  logic             baud_tick,
   input  logic [CNT_W-1:0] delay_ticks,
   output logic             thre,
   output logic             thre_set
);

   initial begin
      if (TICKS_PER_BIT < 1) $error("thr_delay_timer: TICKS_PER_BIT must be positive");
      if (CNT_W < 2)         $error("thr_delay_timer: CNT_W too small");
   end

   logic fifo_empty;
   assign fifo_empty = (fifo_level == '0);

   generate
      if (DELAY_EN) begin : g_delayed
         logic             waiting;
         logic [CNT_W-1:0] remain;
         logic             start_now;
         logic             skip_now;
         logic             expire;

         assign start_now = fifo_empty && !thre && !waiting;
         assign skip_now  = start_now && multi_seen;
         assign expire    = fifo_empty && waiting && baud_tick && (remain <= CNT_W'(1));
         assign thre_set  = skip_now || expire;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               thre    <= 1'b1;
               waiting <= 1'b0;
               remain  <= '0;
            end else if (!fifo_empty) begin
               thre    <= 1'b0;
               waiting <= 1'b0;
               remain  <= '0;
            end else if (skip_now) begin
               thre    <= 1'b1;
            end else if (start_now) begin
               waiting <= 1'b1;
               remain  <= delay_ticks;
            end else if (waiting && baud_tick) begin
               remain  <= remain - CNT_W'(1);
               if (expire) begin
                  thre    <= 1'b1;
                  waiting <= 1'b0;
               end
            end
         end

         AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            (waiting && fifo_empty && !baud_tick) |=> $stable(remain));  // R10
         AST_RISE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(thre) |-> $past(waiting || multi_seen));  // R5
         AST_REFILL_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
            (!fifo_empty) |=> (!waiting && !thre));  // R8
      end else begin : g_immediate
         assign thre_set = fifo_empty && !thre;

         always_ff @(posedge clk) begin
            if (!rst_n) thre <= 1'b1;
            else        thre <= fifo_empty;
         end

         AST_IMM_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (!fifo_empty) |=> !thre);  // R8
      end
   endgenerate

endmodule

// File: rtl/thr_irq_latch.sv
module thr_irq_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic fifo_en,
   input  logic txint_en,
   input  logic thre,
   input  logic thre_set,
   input  logic thr_wr,
   input  logic iir_rd,
   output logic pending
);

   logic fifo_en_q;
   logic txint_en_q;
   logic both_en;
   logic en_edge;
   logic clear_req;

   assign both_en   = fifo_en && txint_en;
   assign en_edge   = both_en && thre &&
                      ((fifo_en && !fifo_en_q) || (txint_en && !txint_en_q));
   assign clear_req = thr_wr || iir_rd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fifo_en_q  <= 1'b0;
         txint_en_q <= 1'b0;
         pending    <= 1'b0;
      end else begin
         fifo_en_q  <= fifo_en;
         txint_en_q <= txint_en;
         if (clear_req)                   pending <= 1'b0;
         else if (thre_set && both_en)    pending <= 1'b1;
         else if (en_edge)                pending <= 1'b1;
      end
   end

   AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      thr_wr |=> !pending);  // R3
   AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      iir_rd |=> !pending);  // R4
   AST_PEND_NEEDS_THRE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pending) |-> thre);  // R5

endmodule

// File: rtl/thr_empty_irq.sv
module thr_empty_irq #(
   parameter int unsigned FIFO_DEPTH    = 16,
   parameter int unsigned TICKS_PER_BIT = 16,
   parameter bit          DELAY_EN      = 1'b1,
   localparam int unsigned LVL_W        = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_en,
   input  logic             txint_en,
   input  logic [LVL_W-1:0] fifo_level,
   input  logic             thr_wr,
   input  logic             iir_rd,
   input  logic             baud_tick,
   input  logic [1:0]       data_len,
   input  logic             parity_en,
   input  logic             two_stop,
   output logic             irq
);
   import thr_empty_pkg::*;

   localparam int unsigned MAX_DELAY = TICKS_PER_BIT * (MAX_FRAME_BITS - 1);
   localparam int unsigned CNT_W     = $clog2(MAX_DELAY + 1);

   initial begin
      if (FIFO_DEPTH < 2)    $error("thr_empty_irq: FIFO_DEPTH must be at least 2");
      if (TICKS_PER_BIT < 1) $error("thr_empty_irq: TICKS_PER_BIT must be positive");
   end

   logic [CNT_W-1:0] delay_ticks;
   logic             thre;
   logic             thre_set;
   logic             multi_seen;
   logic             pending;

   // Frame time less the final stop bit, in oversampling ticks
   always_comb begin
      delay_ticks = CNT_W'(TICKS_PER_BIT * (frame_bits(data_len, parity_en, two_stop) - 1));
   end

   thr_occupancy_tracker #(.LVL_W(LVL_W)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .fifo_level (fifo_level),
      .empty_event(thre_set),
      .multi_seen (multi_seen)
   );

   thr_delay_timer #(
      .LVL_W        (LVL_W),
      .TICKS_PER_BIT(TICKS_PER_BIT),
      .DELAY_EN     (DELAY_EN),
      .CNT_W        (CNT_W)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .fifo_level (fifo_level),
      .multi_seen (multi_seen),
      .baud_tick  (baud_tick),
      .delay_ticks(delay_ticks),
      .thre       (thre),
      .thre_set   (thre_set)
   );

   thr_irq_latch u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .fifo_en (fifo_en),
      .txint_en(txint_en),
      .thre    (thre),
      .thre_set(thre_set),
      .thr_wr  (thr_wr),
      .iir_rd  (iir_rd),
      .pending (pending)
   );

   assign irq = pending && fifo_en && txint_en;

   AST_FULL_NO_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_level != '0 && !irq) |=> !irq || $rose(fifo_en) || $rose(txint_en));  // R5
   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> !pending);  // R1

endmodule

// File: tb/sim_thr_empty_irq.sv
module sim_thr_empty_irq;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       fifo_en, txint_en, thr_wr, iir_rd, baud_tick, parity_en, two_stop;
   logic [4:0] fifo_level;
   logic [1:0] data_len;
   logic       irq;

   int checks   = 0;
   int failures = 0;

   always #4 clk = ~clk;

   thr_empty_irq u0 (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .txint_en(txint_en),
      .fifo_level(fifo_level), .thr_wr(thr_wr), .iir_rd(iir_rd),
      .baud_tick(baud_tick), .data_len(data_len), .parity_en(parity_en),
      .two_stop(two_stop), .irq(irq)
   );

   // {data_len[1:0], parity_en, two_stop, expected delay[7:0]}
   localparam logic [11:0] VEC [8] = '{
      {2'd0, 1'b0, 1'b0, 8'd96},
      {2'd1, 1'b0, 1'b0, 8'd112},
      {2'd2, 1'b0, 1'b0, 8'd128},
      {2'd3, 1'b0, 1'b0, 8'd144},
      {2'd3, 1'b1, 1'b0, 8'd160},
      {2'd3, 1'b0, 1'b1, 8'd160},
      {2'd3, 1'b1, 1'b1, 8'd176},
      {2'd0, 1'b1, 1'b1, 8'd128}
   };

   task automatic step(input int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s irq=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic ticks(input int n);
      baud_tick = 1'b1;
      step(n);
      baud_tick = 1'b0;
   endtask

   // Load one character, drain it, clear any request
   task automatic single_episode();
      fifo_level = 5'd1; thr_wr = 1'b1; step(1);
      thr_wr = 1'b0; step(1);
      fifo_level = 5'd0; step(1);
   endtask

   initial begin
      #1_000_000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst_n = 1'b0; fifo_en = 1'b0; txint_en = 1'b0; thr_wr = 1'b0; iir_rd = 1'b0;
      baud_tick = 1'b0; fifo_level = 5'd0; data_len = 2'd0; parity_en = 1'b0; two_stop = 1'b0;
      step(3);
      rst_n = 1'b1; step(1);
      chk("R1 reset irq low", irq, 1'b0);
      fifo_en = 1'b1; txint_en = 1'b1; step(1);
      chk("R1/R9 empty status set after reset", irq, 1'b1);
      iir_rd = 1'b1; step(1); iir_rd = 1'b0;
      chk("R4 iir read clears", irq, 1'b0);

      // Table walk: delay per frame shape
      foreach (VEC[k]) begin
         data_len  = VEC[k][11:10];
         parity_en = VEC[k][9];
         two_stop  = VEC[k][8];
         single_episode();
         ticks(int'(VEC[k][7:0]) - 1);
         chk($sformatf("R5 vec%0d one tick early", k), irq, 1'b0);
         ticks(1);
         chk($sformatf("R5 vec%0d at full delay", k), irq, 1'b1);
         iir_rd = 1'b1; step(1); iir_rd = 1'b0;
      end

      // R10: idle cycles without ticks do not advance
      data_len = 2'd0; parity_en = 1'b0; two_stop = 1'b0;
      single_episode();
      ticks(50); step(200); ticks(45);
      chk("R10 no advance without tick", irq, 1'b0);
      ticks(1);
      chk("R10 fires at 96th tick", irq, 1'b1);

      // R3: write clears
      thr_wr = 1'b1; step(1); thr_wr = 1'b0;
      chk("R3 thr write clears", irq, 1'b0);

      // R6: two characters at once, no delay
      fifo_level = 5'd1; step(1); fifo_level = 5'd2; step(1);
      fifo_level = 5'd1; step(1);
      chk("R6 no irq while not empty", irq, 1'b0);
      fifo_level = 5'd0; step(1);
      chk("R6 immediate irq", irq, 1'b1);
      iir_rd = 1'b1; step(1); iir_rd = 1'b0;

      // R7: record cleared, next single episode delayed again
      single_episode();
      chk("R7 delayed again", irq, 1'b0);
      ticks(95);
      chk("R7 still waiting", irq, 1'b0);
      ticks(1);
      chk("R7 fires after full delay", irq, 1'b1);
      iir_rd = 1'b1; step(1); iir_rd = 1'b0;

      // R8: refill during delay cancels and restarts
      single_episode();
      ticks(80);
      fifo_level = 5'd1; step(1); fifo_level = 5'd0; step(1);
      ticks(20);
      chk("R8 old delay cancelled", irq, 1'b0);
      ticks(75);
      chk("R8 new delay one short", irq, 1'b0);
      ticks(1);
      chk("R8 new delay completes", irq, 1'b1);

      // R2: masking
      txint_en = 1'b0; #1;
      chk("R2 txint_en masks", irq, 1'b0);
      step(1);
      iir_rd = 1'b1; step(1); iir_rd = 1'b0;
      // R9: enable edges re-raise
      txint_en = 1'b1; step(1);
      chk("R9 txint_en rise raises", irq, 1'b1);
      fifo_en = 1'b0; #1;
      chk("R2 fifo_en masks", irq, 1'b0);
      step(1);
      iir_rd = 1'b1; step(1); iir_rd = 1'b0;
      fifo_en = 1'b1; step(1);
      chk("R9 fifo_en rise raises", irq, 1'b1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule